// File: doc/BRIEF.md
# Queue-to-FIFO Priority Transmit Scheduler

This block decides which transmit queue sends its next descriptor. Up to sixteen circular descriptor queues each report whether they hold work. Software ties every queue to one of eight DMA FIFO channels and switches it on or off. Each FIFO channel reports whether it can take a descriptor. The block issues one grant at a time. A grant names the queue, the descriptor index at that queue's head and the FIFO channel that will carry it.

Arbitration has two levels. Among FIFO channels, the higher channel number always wins. Channel 7 carries commands and sits above every data channel. Channels 3, 2, 1 and 0 carry voice/management, video, best-effort and background traffic, in falling order. Several queues may share a channel, and those queues take turns in round-robin order. The block keeps an 8-bit read pointer per queue. The pointer moves forward when the consumer takes the grant.

Top module: `txq_prio_sched`

## Requirements
- R1: After reset no grant is pending and every queue is inactive, so nothing is granted even if every queue reports work.
- R2: A queue is granted only when it is active, reports not-empty, and the FIFO channel it maps to has its ready flag high.
- R3: Among FIFO channels that are ready and have an eligible queue, the channel with the highest number wins, so channel 7 (commands) beats channel 3, channel 3 beats 2, 2 beats 1, and 1 beats 0.
- R4: Queues mapped to the same channel are served round-robin. The search starts at the queue after the last one accepted on that channel, and the turn moves only when a grant is accepted.
- R5: A pending grant keeps its queue, descriptor index and channel unchanged until `gnt_ready` takes it, whatever the other inputs do.
- R6: Each queue's read pointer starts at 0. It increases by one for each accepted grant of that queue and wraps from 255 to 0. The granted descriptor index is the pointer value before the increment.
- R7: A configuration word holds the channel number in bits [2:0] and the active flag in bit 3. A write to the queue that holds the pending grant is held back and applied when that grant is accepted. A write to any other queue applies at the next clock edge.
- R8: When a queue is remapped to another channel, its later grants carry the new channel and follow that channel's priority and ready flag.
- R9: A grant is issued at the first clock edge at which no grant is pending and some request is eligible. After an accept, `gnt_valid` is low for one cycle before the next grant.

Two more behaviours are built in. Queues 0 to 6 default to channels 0 to 6, and the remaining queues default to channels 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_queue | input | 4 | Queue the configuration write targets |
| cfg_word | input | 4 | [2:0] channel number, [3] active flag |
| q_nonempty | input | 16 | Per-queue flag: descriptors waiting |
| fifo_ready | input | 8 | Per-channel flag: channel accepts a descriptor |
| gnt_valid | output | 1 | A grant is pending |
| gnt_ready | input | 1 | Consumer takes the pending grant |
| gnt_queue | output | 4 | Granted queue |
| gnt_desc | output | 8 | Descriptor index at the granted queue's head |
| gnt_fifo | output | 3 | Channel that carries the grant |

## Verification
The bench targets four hazards.

- **Round-robin turn.** It checks that the turn resumes after the queue last accepted on a shared channel. A design that restarted at queue 0 would serve the low-numbered queue again.
- **Stalled grant.** It holds a grant unaccepted while a higher-priority request appears. A design that re-arbitrated would switch queues in the middle of a handshake.
- **Pointer wrap.** It takes one queue through 257 accepts to see the pointer wrap from 255 to 0.
- **Configuration during a grant.** It rewrites the queue that holds the pending grant. A design that applied the write at once would change the channel of that grant, or cancel it, before it completes.

// File: rtl/txq_prio_sched.sv
module txq_prio_sched #(
  parameter int NQ = 16,
  parameter int NF = 8,
  parameter int PW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NQ)-1:0]    cfg_queue,
  input  logic [$clog2(NF):0]      cfg_word,
  input  logic [NQ-1:0]            q_nonempty,
  input  logic [NF-1:0]            fifo_ready,
  output logic                     gnt_valid,
  input  logic                     gnt_ready,
  output logic [$clog2(NQ)-1:0]    gnt_queue,
  output logic [PW-1:0]            gnt_desc,
  output logic [$clog2(NF)-1:0]    gnt_fifo
);
  localparam int QW = $clog2(NQ);
  localparam int FW = $clog2(NF);

  logic [FW-1:0] q_map  [NQ];
  logic [NQ-1:0] q_act;
  logic [PW-1:0] rd_ptr [NQ];
  logic [QW-1:0] rr     [NF];

  logic          pend_v;
  logic [QW-1:0] pend_q;
  logic [FW:0]   pend_word;

  logic [NF-1:0] fifo_req;
  logic          win_any, win_found;
  logic [FW-1:0] win_f;
  logic [QW-1:0] win_q, scan_q;

  wire accept   = gnt_valid & gnt_ready;
  wire cfg_hold = cfg_we & ((gnt_valid & ~accept & (cfg_queue == gnt_queue)) |
                            (~gnt_valid & win_any & (cfg_queue == win_q)));

  always_comb begin
    fifo_req = '0;
    for (int f = 0; f < NF; f++)
      for (int q = 0; q < NQ; q++)
        if (q_act[q] && q_nonempty[q] && q_map[q] == FW'(f)) fifo_req[f] = 1'b1;
    win_any = 1'b0;
    win_f   = '0;
    for (int f = 0; f < NF; f++)
      if (fifo_req[f] && fifo_ready[f]) begin
        win_any = 1'b1;
        win_f   = FW'(f);
      end
    win_found = 1'b0;
    win_q     = '0;
    scan_q    = '0;
    for (int k = 0; k < NQ; k++) begin
      scan_q = QW'((int'(rr[win_f]) + k) % NQ);
      if (!win_found && q_act[scan_q] && q_nonempty[scan_q] && q_map[scan_q] == win_f) begin
        win_found = 1'b1;
        win_q     = scan_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_queue <= '0;
      gnt_desc  <= '0;
      gnt_fifo  <= '0;
      q_act     <= '0;
      pend_v    <= 1'b0;
      pend_q    <= '0;
      pend_word <= '0;
      for (int q = 0; q < NQ; q++) begin
        q_map[q]  <= (q < NF - 1) ? FW'(q) : FW'(q % 4);
        rd_ptr[q] <= '0;
      end
      for (int f = 0; f < NF; f++) rr[f] <= '0;
    end else begin
      if (accept) begin
        gnt_valid           <= 1'b0;
        rd_ptr[gnt_queue]   <= rd_ptr[gnt_queue] + PW'(1);
        rr[gnt_fifo]        <= (int'(gnt_queue) == NQ - 1) ? '0 : gnt_queue + QW'(1);
        if (pend_v) begin
          q_map[pend_q] <= pend_word[FW-1:0];
          q_act[pend_q] <= pend_word[FW];
          pend_v        <= 1'b0;
        end
      end else if (!gnt_valid && win_any) begin
        gnt_valid <= 1'b1;
        gnt_queue <= win_q;
        gnt_fifo  <= win_f;
        gnt_desc  <= rd_ptr[win_q];
      end
      if (cfg_hold) begin
        pend_v    <= 1'b1;
        pend_q    <= cfg_queue;
        pend_word <= cfg_word;
      end else if (cfg_we) begin
        q_map[cfg_queue] <= cfg_word[FW-1:0];
        q_act[cfg_queue] <= cfg_word[FW];
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_queue) && $stable(gnt_desc) && $stable(gnt_fifo));

  p_cfg_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> q_act[gnt_queue] && q_map[gnt_queue] == gnt_fifo);

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> (($past(fifo_ready) >> gnt_fifo) & NF'(1)) == NF'(1));

  p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> ($past(fifo_req & fifo_ready) >> gnt_fifo) == NF'(1));

  p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gnt_valid);
endmodule

// File: tb/sim_txq_prio_sched.sv
module sim_txq_prio_sched;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_queue = 0;
  logic [3:0]  cfg_word = 0;
  logic [15:0] q_nonempty = 0;
  logic [7:0]  fifo_ready = 8'hFF;
  logic        gnt_ready = 0;
  logic        gnt_valid;
  logic [3:0]  gnt_queue;
  logic [7:0]  gnt_desc;
  logic [2:0]  gnt_fifo;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  txq_prio_sched u0 (.clk, .rst_n, .cfg_we, .cfg_queue, .cfg_word, .q_nonempty,
    .fifo_ready, .gnt_valid, .gnt_ready, .gnt_queue, .gnt_desc, .gnt_fifo);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(int q, int f, int act);
    @(negedge clk);
    cfg_we = 1; cfg_queue = 4'(q); cfg_word = {1'(act), 3'(f)};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_gnt();
    for (int n = 0; n < 8 && !gnt_valid; n++) @(negedge clk);
  endtask

  task automatic take(int q, int d, int f, string tag);
    wait_gnt();
    chk({tag, " valid"}, gnt_valid, 1);
    chk({tag, " queue"}, gnt_queue, q);
    chk({tag, " desc"},  gnt_desc, d);
    chk({tag, " fifo"},  gnt_fifo, f);
    gnt_ready = 1;
    @(negedge clk);
    gnt_ready = 0;
    chk("R9 bubble after accept", gnt_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 no grant in reset state", gnt_valid, 0);
    q_nonempty = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 inactive queues not granted", gnt_valid, 0);
    q_nonempty = 0;
  endtask

  task automatic t_prio();
    cfg(0, 0, 1); cfg(1, 1, 1); cfg(2, 2, 1); cfg(3, 3, 1); cfg(7, 7, 1);
    q_nonempty = 16'h008F;
    take(7, 0, 7, "R3 command first");
    q_nonempty[7] = 0;
    take(3, 0, 3, "R3 voice next");
    fifo_ready[3] = 0;
    take(2, 0, 2, "R2 unready fifo skipped");
    q_nonempty[2] = 0;
    take(1, 0, 1, "R3 best effort over background");
    q_nonempty = 0;
    fifo_ready = 8'hFF;
  endtask

  task automatic t_rr();
    cfg(8, 1, 1); cfg(9, 1, 1);
    q_nonempty = 16'h0302;
    take(8, 0, 1, "R4 rr after q1");
    take(9, 0, 1, "R4 rr q9");
    take(1, 1, 1, "R4 rr wraps to q1");
    take(8, 1, 1, "R4 rr back to q8");
    q_nonempty = 0;
  endtask

  task automatic t_hold();
    q_nonempty[9] = 1;
    wait_gnt();
    for (int i = 0; i < 4; i++) begin
      q_nonempty[7] = 1;
      q_nonempty[0] = i[0];
      @(negedge clk);
      chk("R5 valid held", gnt_valid, 1);
      chk("R5 queue held", gnt_queue, 9);
      chk("R5 desc held", gnt_desc, 1);
    end
    q_nonempty = 16'h0280;
    take(9, 1, 1, "R5 accepted");
    q_nonempty[9] = 0;
    take(7, 1, 7, "R3 command after stall");
    q_nonempty = 0;
  endtask

  task automatic t_move();
    fifo_ready = 8'hFD;
    cfg(9, 2, 1);
    q_nonempty[9] = 1;
    take(9, 2, 2, "R8 remapped queue");
    q_nonempty = 0;
    fifo_ready = 8'hFF;
  endtask

  task automatic t_wrap();
    cfg(5, 5, 1);
    q_nonempty[5] = 1;
    for (int i = 0; i < 257; i++) take(5, i % 256, 5, "R6 pointer");
  endtask

  task automatic t_defer();
    wait_gnt();
    cfg(5, 6, 1);
    chk("R7 held write valid", gnt_valid, 1);
    chk("R7 held write fifo", gnt_fifo, 5);
    take(5, 1, 5, "R7 old mapping");
    take(5, 2, 6, "R7 new mapping");
    wait_gnt();
    cfg(5, 6, 0);
    chk("R7 deactivate deferred", gnt_valid, 1);
    take(5, 3, 6, "R7 grant completes");
    repeat (3) @(negedge clk);
    chk("R7 inactive after deferred write", gnt_valid, 0);
    q_nonempty = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prio();
    t_rr();
    t_hold();
    t_move();
    t_wrap();
    t_defer();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule